// File: doc/BRIEF.md
# Radix-4 SRT Quotient/Root Digit Selector

This block chooses the next digit of a radix-4 SRT recurrence that serves both division and square root. Each iteration it receives the top eight bits of the partial remainder, already in plain two's-complement form, and four signed selection limits. Logic outside the block derives those limits from the divisor or from the current root estimate. All four comparisons run side by side. The chosen digit comes out as a five-bit one-hot word, so it can drive the select lines of wide remainder and root multiplexers without any decoding.

The remainder bits arrive non-redundant, so no carry-propagate stage sits in front of the comparators. Each comparator is a single subtraction, and only its sign bit is used. The selection logic is combinational. The top module wraps it in one output register with an asynchronous reset so the block can be exercised in a clocked setting. The digit set is {-2, -1, 0, +1, +2}.

Top module: `srt_digit_sel`

## Requirements
- R1: The output code places digit +2 on bit 4, +1 on bit 3, 0 on bit 2, -1 on bit 1 and -2 on bit 0.
- R2: When the remainder is greater than or equal to the top limit (`lim_p2`), the digit is +2.
- R3: When the remainder is below all four limits, the digit is -2.
- R4: With ordered limits `lim_p2 > lim_p1 > lim_z > lim_n1`, a remainder inside `[lim_p1, lim_p2)` gives +1, inside `[lim_z, lim_p1)` gives 0 and inside `[lim_n1, lim_z)` gives -1. A remainder equal to a limit selects the higher digit.
- R5: For every input combination, ordered limits or not, exactly one output bit is high. The digit is the highest one whose limit the remainder meets.
- R6: All comparisons are exact over the full signed 8-bit range, including -128 against +127 and +127 against -128. No result wraps around.
- R7: The digit for the inputs present at a rising clock edge appears on `digit_oh` after that edge. While reset is asserted the output holds digit 0 (`5'b00100`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| rem_msb | input | 8 | Truncated partial remainder, two's complement |
| lim_p2 | input | 8 | Signed limit for digit +2 |
| lim_p1 | input | 8 | Signed limit for digit +1 |
| lim_z | input | 8 | Signed limit for digit 0 |
| lim_n1 | input | 8 | Signed limit for digit -1 |
| digit_oh | output | 5 | Registered one-hot digit |

## Verification
The hardest case to reach from the ports is a comparison whose true difference does not fit in eight bits. An example is a remainder of +127 tested against a limit of -128, where a narrow subtractor would flip the sign and pick the wrong digit. Random values almost never land on these pairs, so directed cases drive the extreme codes against each other. A second hard case is limits that arrive out of order, which can leave several comparators asserted at once. Random limit sets are drawn with no ordering constraint to cover this. A full sweep of all 256 remainder codes against fixed ordered limits covers every equality boundary.

// File: rtl/srt_sel_pkg.sv
package srt_sel_pkg;

  // digit set {-2,-1,0,+1,+2}: one-hot width and number of limits
  localparam int DIG_N = 5;
  localparam int THR_N = DIG_N - 1;

  // one-hot code of digit 0, used as the reset value
  localparam logic [DIG_N-1:0] OH_ZERO = 5'b00100;

  // sign of (a - b) computed one bit wider than the operands, so it never wraps
  function automatic logic diff_neg(input logic [15:0] a, input logic [15:0] b,
                                    input int w);
    logic [16:0] ax;
    logic [16:0] bx;
    logic [16:0] d;
    ax = '0;
    bx = '0;
    for (int i = 0; i < 17; i++) begin
      ax[i] = (i < w) ? a[i] : a[w-1];
      bx[i] = (i < w) ? b[i] : b[w-1];
    end
    d = ax - bx;
    return d[w];
  endfunction

  // is any limit above index t met?
  function automatic logic higher_met(input logic [THR_N-1:0] ge, input int t);
    logic any;
    any = 1'b0;
    for (int j = 0; j < THR_N; j++)
      if (j > t) any = any | ge[j];
    return any;
  endfunction

endpackage

// File: rtl/srt_thr_cmp.sv
module srt_thr_cmp #(
  parameter int REM_W = 8
) (
  input  logic [REM_W-1:0] rem,
  input  logic [REM_W-1:0] lim,
  output logic             meets
);
  import srt_sel_pkg::*;

  logic [15:0] rem_x;
  logic [15:0] lim_x;
  logic        neg;

  always_comb begin
    rem_x = '0;
    lim_x = '0;
    rem_x[REM_W-1:0] = rem;
    lim_x[REM_W-1:0] = lim;
    neg   = diff_neg(rem_x, lim_x, REM_W);
    meets = ~neg;
  end
endmodule

// File: rtl/srt_digit_pick.sv
module srt_digit_pick
  import srt_sel_pkg::*;
(
  input  logic [THR_N-1:0] ge,
  output logic [DIG_N-1:0] onehot
);
  // limit t (0 = digit -1 ... 3 = digit +2) maps to output bit t+1
  for (genvar t = 0; t < THR_N; t++) begin : g_bit
    assign onehot[t+1] = ge[t] & ~higher_met(ge, t);
  end
  assign onehot[0] = ~|ge;
endmodule

// File: rtl/srt_digit_sel.sv
module srt_digit_sel #(
  parameter int REM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REM_W-1:0] rem_msb,
  input  logic [REM_W-1:0] lim_p2,
  input  logic [REM_W-1:0] lim_p1,
  input  logic [REM_W-1:0] lim_z,
  input  logic [REM_W-1:0] lim_n1,
  output logic [4:0]       digit_oh
);
  import srt_sel_pkg::*;

  logic [REM_W-1:0] lim_arr [THR_N];
  logic [THR_N-1:0] ge_vec;
  logic [DIG_N-1:0] sel_code;

  assign lim_arr[0] = lim_n1;
  assign lim_arr[1] = lim_z;
  assign lim_arr[2] = lim_p1;
  assign lim_arr[3] = lim_p2;

  for (genvar k = 0; k < THR_N; k++) begin : g_cmp
    srt_thr_cmp #(.REM_W(REM_W)) u_cmp (
      .rem   (rem_msb),
      .lim   (lim_arr[k]),
      .meets (ge_vec[k])
    );
  end

  srt_digit_pick u_pick (
    .ge     (ge_vec),
    .onehot (sel_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) digit_oh <= OH_ZERO;
    else        digit_oh <= sel_code;
  end
endmodule

// File: rtl/srt_digit_sel_chk.sv
module srt_digit_sel_chk #(
  parameter int REM_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REM_W-1:0] rem_msb,
  input logic [REM_W-1:0] lim_p2,
  input logic [REM_W-1:0] lim_p1,
  input logic [REM_W-1:0] lim_z,
  input logic [REM_W-1:0] lim_n1,
  input logic [3:0]       ge_vec,
  input logic [4:0]       digit_oh
);
  logic ordered;
  assign ordered = ($signed(lim_p2) > $signed(lim_p1)) &&
                   ($signed(lim_p1) > $signed(lim_z)) &&
                   ($signed(lim_z) > $signed(lim_n1));

  AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n) $countones(digit_oh) == 1); // R5
  AST_TOP_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(rem_msb) >= $signed(lim_p2)) |=> digit_oh[4]); // R2
  AST_BOTTOM_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
    (($signed(rem_msb) < $signed(lim_p2)) && ($signed(rem_msb) < $signed(lim_p1)) &&
     ($signed(rem_msb) < $signed(lim_z)) && ($signed(rem_msb) < $signed(lim_n1))) |=> digit_oh[0]); // R3
  AST_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
    ordered |-> (ge_vec == 4'b0000 || ge_vec == 4'b0001 || ge_vec == 4'b0011 ||
                 ge_vec == 4'b0111 || ge_vec == 4'b1111)); // R4
  AST_ZERO_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    (ordered && ($signed(rem_msb) >= $signed(lim_z)) && ($signed(rem_msb) < $signed(lim_p1)))
    |=> digit_oh[2]); // R4
  AST_RESET_VAL: assert property (@(posedge clk) !rst_n |=> digit_oh == 5'b00100); // R7
endmodule

bind srt_digit_sel srt_digit_sel_chk #(.REM_W(REM_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rem_msb  (rem_msb),
  .lim_p2   (lim_p2),
  .lim_p1   (lim_p1),
  .lim_z    (lim_z),
  .lim_n1   (lim_n1),
  .ge_vec   (ge_vec),
  .digit_oh (digit_oh)
);

// File: tb/test_srt_digit_sel.sv
module test_srt_digit_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rem_msb = '0, lim_p2 = '0, lim_p1 = '0, lim_z = '0, lim_n1 = '0;
  logic [4:0] digit_oh;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct {
    logic [4:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk; // 50 MHz

  srt_digit_sel i_srt_digit_sel (
    .clk(clk), .rst_n(rst_n), .rem_msb(rem_msb), .lim_p2(lim_p2), .lim_p1(lim_p1),
    .lim_z(lim_z), .lim_n1(lim_n1), .digit_oh(digit_oh)
  );

  // reference: walk the limits from lowest to highest; the last one met wins
  function automatic logic [4:0] ref_code(int r, int a, int b, int c, int d);
    int idx = 0;
    if (r >= d) idx = 1;
    if (r >= c) idx = 2;
    if (r >= b) idx = 3;
    if (r >= a) idx = 4;
    return 5'b00001 << idx;
  endfunction

  task automatic drive(int r, int a, int b, int c, int d, string tag);
    item_t it;
    @(negedge clk);
    rem_msb = r[7:0]; lim_p2 = a[7:0]; lim_p1 = b[7:0]; lim_z = c[7:0]; lim_n1 = d[7:0];
    it.exp = ref_code(r, a, b, c, d);
    it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: the item driven at a negedge is registered at the following posedge
  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_cmp++;
      if (digit_oh !== it.exp) begin
        n_bad++;
        $display("FAIL %s: digit_oh=%b expected=%b", it.tag, digit_oh, it.exp);
      end
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R7: reset value digit 0
    repeat (3) @(posedge clk);
    #1;
    n_cmp++;
    if (digit_oh !== 5'b00100) begin
      n_bad++;
      $display("FAIL R7: digit_oh=%b expected=00100", digit_oh);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1/R2/R4: exact limit equality picks the higher digit; one below drops it
    drive(24, 24, 8, -8, -24, "R2");
    drive(23, 24, 8, -8, -24, "R4");
    drive(8, 24, 8, -8, -24, "R1");
    drive(7, 24, 8, -8, -24, "R4");
    drive(-8, 24, 8, -8, -24, "R4");
    drive(-9, 24, 8, -8, -24, "R4");
    drive(-24, 24, 8, -8, -24, "R4");
    drive(-25, 24, 8, -8, -24, "R3");
    drive(-128, 24, 8, -8, -24, "R3");
    drive(127, 24, 8, -8, -24, "R2");

    // R6: extremes that overflow an 8-bit difference
    drive(127, -125, -126, -127, -128, "R6");
    drive(-128, 127, 126, 125, 124, "R6");
    drive(-128, 127, 126, 125, -128, "R6");
    drive(127, 127, 126, 125, 124, "R6");
    drive(126, 127, 0, -1, -128, "R6");

    // R4: every remainder code against fixed ordered limits
    for (int r = -128; r < 128; r++) drive(r, 40, 12, -12, -40, "R4");

    // R5: unordered and random limits
    drive(0, -10, 10, 20, -5, "R5");
    drive(15, -10, 10, 20, 30, "R5");
    drive(0, 0, 0, 0, 0, "R5");
    for (int i = 0; i < 1500; i++) begin
      int r = int'($urandom_range(255)) - 128;
      int a = int'($urandom_range(255)) - 128;
      int b = int'($urandom_range(255)) - 128;
      int c = int'($urandom_range(255)) - 128;
      int d = int'($urandom_range(255)) - 128;
      drive(r, a, b, c, d, "R5");
    end

    // R7: output follows the new input one edge later in back-to-back changes
    drive(50, 30, 10, -10, -30, "R7");
    drive(-50, 30, 10, -10, -30, "R7");
    drive(0, 30, 10, -10, -30, "R7");

    repeat (4) @(posedge clk);
    #2;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule